// File: doc/BRIEF.md
# Thermal Clock-Throttle Duty Controller

This block decides, slot by slot, whether the core clock may run. Each gating period has eight slots, and each slot lasts a fixed number of clocks. A clock-enable output stays high for the first N slots of every period and low for the rest, so the core runs N eighths of the time. Two sources can set N. Software can request a duty in eighths (12.5% steps) through a 3-bit code. Hardware can also force throttling from a digital over-temperature trip, which comes from an analog comparator outside the block.

The trip input is asynchronous. It passes through a two-flop synchroniser before any logic uses it. The synchronised value also drives an active-low hot indicator. When automatic throttling is enabled and the trip is present, the automatic duty of four slots in eight wins over any software request. A new duty, whatever its source, is sampled only at the period boundary, so a period is never cut short or stretched.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: `hot_n_o` goes low exactly two rising clock edges after `trip_i` goes high, and returns high two edges after `trip_i` goes low.
- R2: With software throttling enabled, automatic throttling not in force, and duty code k in 1..7, `clk_en_o` is high during slots 0..k-1 of each period and low during slots k..7.
- R3: Duty code 0 with software throttling enabled means no throttling: `clk_en_o` stays high for the whole period.
- R4: With neither source active, `clk_en_o` stays high continuously.
- R5: With automatic throttling enabled and the trip present, `clk_en_o` is high for slots 0..3 and low for slots 4..7 (default `AUTO_SLOTS` = 4).
- R6: When both sources are enabled and the trip is present, the automatic duty applies whatever the software code is.
- R7: With automatic throttling enabled but no trip present, the software request (or full-on, if software is off) governs.
- R8: A change of source or code takes effect only at the next period boundary. The current period finishes with the duty it started with.
- R9: Each slot lasts `SLOT_CLKS` clocks and a period lasts 8 × `SLOT_CLKS` clocks. Slot 0 of the first period starts in the cycle after the last reset edge.
- R10: While `rst` is high, `clk_en_o` is high and `hot_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Asynchronous over-temperature trip, high when hot |
| auto_en_i | input | 1 | Enables automatic throttling on trip |
| od_en_i | input | 1 | Enables software-requested throttling |
| od_duty_i | input | 3 | Software duty code: k means k of 8 slots enabled, 0 means none throttled |
| clk_en_o | output | 1 | Core clock enable pulse train |
| hot_n_o | output | 1 | Active-low synchronised hot indicator |

## Verification
The hardest situation to reach is an input change that lands in the middle of a period. The enable pattern must then keep the old duty up to the boundary and switch exactly there. The bench keeps its own count of clocks since reset to locate each slot. It changes the software code at the start of slot 1 and checks the rest of that period against the old duty and the next period against the new one. The bench also raises the trip while a software code is active, which tests the precedence of automatic throttling. To test the synchroniser delay, it samples `hot_n_o` one edge and then two edges after the trip changes.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Duty code width: one code step is one slot of the period
    localparam int DUTY_W = 3;
    localparam int SLOTS  = 1 << DUTY_W;
    localparam int ON_W   = DUTY_W + 1;

    typedef logic [DUTY_W-1:0] duty_code_t;
    typedef logic [ON_W-1:0]   on_cnt_t;

    // Which source owns the gating during a period
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_DEMAND = 2'd1,
        SRC_AUTO   = 2'd2
    } gate_src_e;

    // Plan latched at a period boundary
    typedef struct packed {
        gate_src_e  src;
        duty_code_t code;
    } gate_plan_t;

    // Priority: automatic on trip, then a non-zero software code, else full on
    function automatic gate_plan_t pick_plan(input logic auto_en,
                                             input logic hot,
                                             input logic dem_en,
                                             input duty_code_t code);
        gate_plan_t p;
        p.code = code;
        if (auto_en && hot)
            p.src = SRC_AUTO;
        else if (dem_en && (code != '0))
            p.src = SRC_DEMAND;
        else
            p.src = SRC_NONE;
        return p;
    endfunction

endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/thr_slot_timer.sv
module thr_slot_timer
    import thr_pkg::*;
#(
    parameter int SLOT_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    output duty_code_t slot_idx,
    output logic       period_wrap
);
    localparam int TICK_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_CLKS - 1);
    localparam duty_code_t SLOT_LAST = duty_code_t'(SLOTS - 1);

    logic [TICK_W-1:0] tick_q;
    logic              slot_end;

    assign slot_end    = (tick_q == TICK_LAST);
    assign period_wrap = slot_end && (slot_idx == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q   <= '0;
            slot_idx <= '0;
        end else if (slot_end) begin
            tick_q   <= '0;
            slot_idx <= slot_idx + 1'b1;
        end else begin
            tick_q   <= tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/thr_duty_sel.sv
module thr_duty_sel
    import thr_pkg::*;
#(
    parameter int AUTO_SLOTS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       period_wrap,
    input  logic       auto_en,
    input  logic       hot,
    input  logic       dem_en,
    input  duty_code_t dem_code,
    output on_cnt_t    on_slots
);
    gate_plan_t plan_d;
    gate_plan_t plan_q;

    always_comb plan_d = pick_plan(auto_en, hot, dem_en, dem_code);

    // New plan only at the period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q.src  <= SRC_NONE;
            plan_q.code <= '0;
        end else if (period_wrap) begin
            plan_q <= plan_d;
        end
    end

    always_comb begin
        case (plan_q.src)
            SRC_AUTO:   on_slots = on_cnt_t'(AUTO_SLOTS);
            SRC_DEMAND: on_slots = {1'b0, plan_q.code};
            default:    on_slots = on_cnt_t'(SLOTS);
        endcase
    end

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int SLOT_CLKS   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AUTO_SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trip_i,
    input  logic              auto_en_i,
    input  logic              od_en_i,
    input  logic [DUTY_W-1:0] od_duty_i,
    output logic              clk_en_o,
    output logic              hot_n_o
);
    logic       trip_s;
    duty_code_t slot_idx;
    logic       period_wrap;
    on_cnt_t    on_slots;

    thr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (trip_i),
        .q   (trip_s)
    );

    thr_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .slot_idx    (slot_idx),
        .period_wrap (period_wrap)
    );

    thr_duty_sel #(.AUTO_SLOTS(AUTO_SLOTS)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .period_wrap (period_wrap),
        .auto_en     (auto_en_i),
        .hot         (trip_s),
        .dem_en      (od_en_i),
        .dem_code    (od_duty_i),
        .on_slots    (on_slots)
    );

    assign clk_en_o = ({1'b0, slot_idx} < on_slots);
    assign hot_n_o  = ~trip_s;

endmodule

// File: rtl/thermal_throttle_ctrl_chk.sv
module thermal_throttle_ctrl_chk
    import thr_pkg::*;
#(
    parameter int SLOT_CLKS   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AUTO_SLOTS  = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       trip_i,
    input logic       auto_en_i,
    input logic       od_en_i,
    input logic       clk_en_o,
    input logic       hot_n_o,
    input logic       period_wrap,
    input duty_code_t slot_idx,
    input on_cnt_t    on_slots
);
    int unsigned tick_ref;
    logic [1:0]  seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_ref <= 0;
            seen     <= '0;
        end else begin
            tick_ref <= (tick_ref == SLOT_CLKS - 1) ? 0 : tick_ref + 1;
            if (seen != 2'd2) seen <= seen + 2'd1;
        end
    end

    generate
        if (SYNC_STAGES == 2) begin : g_sync2
            // R1
            hot_sync_chk: assert property (@(posedge clk) disable iff (rst)
                (seen == 2'd2) |-> (hot_n_o == !$past(trip_i, 2)));
        end
    endgenerate

    // R9
    slot_len_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_idx != $past(slot_idx)) |->
            ((tick_ref == 0) && (slot_idx == $past(slot_idx) + 1'b1)));

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_wrap |=> $stable(on_slots));

    // R6
    auto_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (period_wrap && auto_en_i && od_en_i && !hot_n_o) |=>
            (on_slots == on_cnt_t'(AUTO_SLOTS)));

    // R4
    idle_full_chk: assert property (@(posedge clk) disable iff (rst)
        (period_wrap && !auto_en_i && !od_en_i) |=> (on_slots == on_cnt_t'(SLOTS)));

    // R4
    full_high_chk: assert property (@(posedge clk) disable iff (rst)
        (on_slots == on_cnt_t'(SLOTS)) |-> clk_en_o);

endmodule

bind thermal_throttle_ctrl thermal_throttle_ctrl_chk #(
    .SLOT_CLKS   (SLOT_CLKS),
    .SYNC_STAGES (SYNC_STAGES),
    .AUTO_SLOTS  (AUTO_SLOTS)
) u_chk (.*);

// File: tb/thermal_throttle_ctrl_tb.sv
module thermal_throttle_ctrl_tb;
    localparam int SLOT_CLKS = 4;
    localparam int PERIOD    = 8 * SLOT_CLKS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trip_i = 1'b0;
    logic       auto_en_i = 1'b0;
    logic       od_en_i = 1'b0;
    logic [2:0] od_duty_i = 3'd0;
    logic       clk_en_o;
    logic       hot_n_o;

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    bit done = 0;

    thermal_throttle_ctrl #(.SLOT_CLKS(SLOT_CLKS)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .trip_i    (trip_i),
        .auto_en_i (auto_en_i),
        .od_en_i   (od_en_i),
        .od_duty_i (od_duty_i),
        .clk_en_o  (clk_en_o),
        .hot_n_o   (hot_n_o)
    );

    always #5 clk = ~clk;

    // Clocks since reset release: period position at each falling edge
    always @(posedge clk) begin
        if (rst) tcount <= 0;
        else     tcount <= tcount + 1;
    end

    function automatic int pos();
        return tcount % PERIOD;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Compare clk_en_o over one whole period against the first exp_on slots high
    task automatic check_period(input string req, input int exp_on);
        int bad_pos = -1;
        logic bad_val = 1'b0;
        while (pos() != 0) @(negedge clk);
        for (int i = 0; i < PERIOD; i++) begin
            if (bad_pos < 0 && clk_en_o !== ((i / SLOT_CLKS) < exp_on)) begin
                bad_pos = i;
                bad_val = clk_en_o;
            end
            @(negedge clk);
        end
        checks++;
        if (bad_pos >= 0) begin
            errors++;
            $display("FAIL %s: clk_en at position %0d actual %0b expected %0b (duty %0d/8)",
                     req, bad_pos, bad_val, (bad_pos / SLOT_CLKS) < exp_on, exp_on);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R10 clk_en in reset", clk_en_o, 1'b1);
        check_bit("R10 hot_n in reset", hot_n_o, 1'b1);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle();
        auto_en_i = 0; od_en_i = 0; trip_i = 0;
        settle();
        check_period("R4 neither source", 8);
        check_period("R9 idle second period", 8);
    endtask

    task automatic t_demand_sweep();
        od_en_i = 1;
        for (int k = 1; k < 8; k++) begin
            od_duty_i = 3'(k);
            settle();
            check_period($sformatf("R2 demand code %0d", k), k);
        end
        od_duty_i = 3'd0;
        settle();
        check_period("R3 demand code 0", 8);
    endtask

    task automatic t_auto_no_trip();
        auto_en_i = 1; od_en_i = 0; trip_i = 0;
        settle();
        check_period("R7 auto without trip, demand off", 8);
        od_en_i = 1; od_duty_i = 3'd5;
        settle();
        check_period("R7 auto without trip, demand 5", 5);
    endtask

    task automatic t_trip();
        auto_en_i = 1; od_en_i = 1; od_duty_i = 3'd6;
        @(negedge clk);
        trip_i = 1;
        @(negedge clk);
        check_bit("R1 hot_n after one edge", hot_n_o, 1'b1);
        @(negedge clk);
        check_bit("R1 hot_n after two edges", hot_n_o, 1'b0);
        settle();
        check_period("R6 auto beats demand 6", 4);
        od_duty_i = 3'd1;
        settle();
        check_period("R6 auto beats demand 1", 4);
        od_en_i = 0;
        settle();
        check_period("R5 auto only on trip", 4);
        auto_en_i = 0; od_en_i = 1; od_duty_i = 3'd3;
        settle();
        check_period("R2 trip with auto off follows demand 3", 3);
        check_bit("R1 hot_n held while trip", hot_n_o, 1'b0);
        trip_i = 0;
        @(negedge clk);
        check_bit("R1 hot_n stays low one edge after release", hot_n_o, 1'b0);
        @(negedge clk);
        check_bit("R1 hot_n high two edges after release", hot_n_o, 1'b1);
    endtask

    task automatic t_mid_period();
        int bad_pos = -1;
        auto_en_i = 0; od_en_i = 1; od_duty_i = 3'd7;
        settle();
        check_period("R8 baseline demand 7", 7);
        while (pos() != SLOT_CLKS) @(negedge clk);
        od_duty_i = 3'd2;
        while (pos() != 0) begin
            if (bad_pos < 0 && clk_en_o !== ((pos() / SLOT_CLKS) < 7)) bad_pos = pos();
            @(negedge clk);
        end
        checks++;
        if (bad_pos >= 0) begin
            errors++;
            $display("FAIL R8 old duty kept mid-period: position %0d actual %0b expected %0b",
                     bad_pos, !((bad_pos / SLOT_CLKS) < 7), (bad_pos / SLOT_CLKS) < 7);
        end
        check_period("R8 new duty at boundary", 2);
        od_en_i = 0;
        settle();
        check_period("R4 demand released", 8);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_demand_sweep();
        t_auto_no_trip();
        t_trip();
        t_mid_period();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule